// File: doc/BRIEF.md
# 3x3 Convolution Row Engine

This engine produces one row of a 3x3, stride-1 convolution for a unit of output channels. A row buffer outside the block holds three consecutive input rows for every input channel. The engine walks those rows one column at a time and keeps a sliding 3x3 window. A bank of parallel processing elements, one per output channel of the current unit, multiplies the window by that channel's kernel. Each element sums the nine products with an adder tree.

Work is ordered by input channel. The inner product for input channel 0 starts a per-column, per-lane accumulator, and each later input channel adds into it. During the pass over the last input channel, the finished sums leave the block as an output row stream, one column per cycle. After that the engine moves on to the next unit of output channels.

The engine pads with zeros itself, one pixel on every side, so the output row is as wide as the input row. It does this by comparing the window position against the row width and the top and bottom edge flags. It never fetches stored pad values.

Top module: `conv_row_engine`

## Requirements
- R1: After reset, `busy_o` and `out_valid_o` are low.
- R2: Pixels and weights are 8-bit two's complement. The weight for lane p, window row r (0 = top) and window column c (0 = left) is at `kernel_i[(p*9+r*3+c)*8 +: 8]`. Output lane p, `out_data_o[p*32 +: 32]`, carries output channel `unit*NUM_PE+p`. Its value is the 32-bit two's complement sum, over all input channels and all nine taps, of weight times padded pixel. Accepted configurations have width 1..MAX_W, input channels 1..MAX_CIN and units 1..MAX_UNITS.
- R3: Pixel columns -1 and `width` count as zero. Row-buffer data returned while `rd_col_o` equals the width has no effect on any result.
- R4: While the latched top flag is set, the top window row counts as zero and `rd_top_i` has no effect. The latched bottom flag does the same for the bottom row and `rd_bot_i`.
- R5: A run emits exactly width*units outputs. They come in ascending unit order, and within a unit in columns 0 to width-1 on consecutive cycles. `out_valid_o` is raised only during the pass over the final input channel.
- R6: A `start_i` pulse while `busy_o` is high is ignored. It causes no restart and no extra outputs.
- R7: Configuration and edge flags are sampled only at an accepted start. Changes to them later in the run have no effect on its results.
- R8: `busy_o` is high from the cycle after an accepted start. It goes low in the same cycle as the run's last `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a row computation when idle |
| cfg_width_i | input | COL_W | Row width in pixels |
| cfg_cin_i | input | CH_W | Number of input channels |
| cfg_units_i | input | UNIT_W | Number of output-channel units |
| top_edge_i | input | 1 | Row is the first of the feature map |
| bot_edge_i | input | 1 | Row is the last of the feature map |
| busy_o | output | 1 | Run in progress |
| rd_ch_o | output | CH_W | Row-buffer input-channel address |
| rd_col_o | output | COL_W | Row-buffer column address |
| rd_top_i | input | 8 | Pixel of the upper row at the read address |
| rd_mid_i | input | 8 | Pixel of the centre row at the read address |
| rd_bot_i | input | 8 | Pixel of the lower row at the read address |
| k_ch_o | output | CH_W | Kernel input-channel address |
| k_unit_o | output | UNIT_W | Kernel output-unit address |
| kernel_i | input | NUM_PE*72 | Nine weights per lane for the addressed channel and unit |
| out_valid_o | output | 1 | Output column valid |
| out_unit_o | output | UNIT_W | Unit of the output column |
| out_col_o | output | COL_W | Column index of the output |
| out_data_o | output | NUM_PE*32 | One 32-bit sum per lane |

## Verification
The assertions assume that the row buffer and kernel store answer their addresses in the same cycle. They also assume that every accepted start carries a configuration inside the R2 ranges, and that the data never drives a running sum past 32-bit range. The bench models both stores as combinational functions of the engine's address outputs. It sweeps only legal widths, channel counts and unit counts. Its largest operands (all pixels and weights at -128, maximum width and channel count) stay far below the 32-bit accumulator limit.

// File: rtl/conv_row_pkg.sv
package conv_row_pkg;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 32;
  localparam int KTAPS  = 9;

  typedef logic signed [DATA_W-1:0] pix_t;
  typedef pix_t [KTAPS-1:0] win_t;  // index r*3+c, r=0 top, c=0 left
endpackage

// File: rtl/conv_row_seq.sv
module conv_row_seq #(
  parameter int MAX_W     = 16,
  parameter int MAX_CIN   = 8,
  parameter int MAX_UNITS = 4,
  parameter int COL_W     = 5,
  parameter int CH_W      = 4,
  parameter int UNIT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [COL_W-1:0]  cfg_width_i,
  input  logic [CH_W-1:0]   cfg_cin_i,
  input  logic [UNIT_W-1:0] cfg_units_i,
  input  logic              top_edge_i,
  input  logic              bot_edge_i,
  output logic              run_o,
  output logic [COL_W-1:0]  col_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic [COL_W-1:0]  width_o,
  output logic              top_o,
  output logic              bot_o,
  output logic              first_ch_o,
  output logic              last_ch_o
);
  logic              run_q;
  logic [COL_W-1:0]  col_q, width_q;
  logic [CH_W-1:0]   ch_q, cin_q;
  logic [UNIT_W-1:0] unit_q, units_q;
  logic              top_q, bot_q;
  logic              accept;

  assign accept = start_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      col_q   <= '0;
      ch_q    <= '0;
      unit_q  <= '0;
      width_q <= '0;
      cin_q   <= '0;
      units_q <= '0;
      top_q   <= 1'b0;
      bot_q   <= 1'b0;
    end else if (accept) begin
      run_q   <= 1'b1;
      col_q   <= '0;
      ch_q    <= '0;
      unit_q  <= '0;
      width_q <= cfg_width_i;
      cin_q   <= cfg_cin_i;
      units_q <= cfg_units_i;
      top_q   <= top_edge_i;
      bot_q   <= bot_edge_i;
    end else if (run_q) begin
      // one extra column step per channel feeds the right-hand pad
      if (col_q == width_q) begin
        col_q <= '0;
        if (ch_q == cin_q - CH_W'(1)) begin
          ch_q <= '0;
          if (unit_q == units_q - UNIT_W'(1)) run_q <= 1'b0;
          else unit_q <= unit_q + UNIT_W'(1);
        end else begin
          ch_q <= ch_q + CH_W'(1);
        end
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  assign run_o      = run_q;
  assign col_o      = col_q;
  assign ch_o       = ch_q;
  assign unit_o     = unit_q;
  assign width_o    = width_q;
  assign top_o      = top_q;
  assign bot_o      = bot_q;
  assign first_ch_o = (ch_q == '0);
  assign last_ch_o  = (ch_q == cin_q - CH_W'(1));

  assert_cfg_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (cfg_width_i != '0) && (cfg_width_i <= COL_W'(MAX_W)) &&
               (cfg_cin_i != '0) && (cfg_cin_i <= CH_W'(MAX_CIN)) &&
               (cfg_units_i != '0) && (cfg_units_i <= UNIT_W'(MAX_UNITS)));

  assert_cfg_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(width_q) && $stable(cin_q) &&
                                 $stable(units_q) && $stable(top_q) && $stable(bot_q)));
endmodule

// File: rtl/conv_row_window.sv
module conv_row_window
  import conv_row_pkg::*;
#(
  parameter int COL_W  = 5,
  parameter int CH_W   = 4,
  parameter int UNIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_v_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic              first_ch_i,
  input  logic              last_ch_i,
  input  logic [COL_W-1:0]  width_i,
  input  logic              top_i,
  input  logic              bot_i,
  input  logic [DATA_W-1:0] rd_top_i,
  input  logic [DATA_W-1:0] rd_mid_i,
  input  logic [DATA_W-1:0] rd_bot_i,
  output win_t              win_o,
  output logic              s1_v_o,
  output logic [COL_W-1:0]  s1_col_o,
  output logic [CH_W-1:0]   s1_ch_o,
  output logic [UNIT_W-1:0] s1_unit_o,
  output logic              s1_first_o,
  output logic              s1_last_o
);
  win_t              win_q;
  pix_t [2:0]        new_col;
  logic              right_pad, left_start;
  logic              s1_v_q, s1_first_q, s1_last_q;
  logic [COL_W-1:0]  s1_col_q;
  logic [CH_W-1:0]   s1_ch_q;
  logic [UNIT_W-1:0] s1_unit_q;

  assign right_pad  = (col_i == width_i);
  assign left_start = (col_i == '0);

  // border pixels are forced to zero by position, never read from storage
  always_comb begin
    new_col[0] = (right_pad || top_i) ? '0 : pix_t'(rd_top_i);
    new_col[1] = right_pad            ? '0 : pix_t'(rd_mid_i);
    new_col[2] = (right_pad || bot_i) ? '0 : pix_t'(rd_bot_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (rd_v_i) begin
      for (int r = 0; r < 3; r++) begin
        win_q[r*3+0] <= left_start ? '0 : win_q[r*3+1];
        win_q[r*3+1] <= left_start ? '0 : win_q[r*3+2];
        win_q[r*3+2] <= new_col[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q     <= 1'b0;
      s1_col_q   <= '0;
      s1_ch_q    <= '0;
      s1_unit_q  <= '0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
    end else begin
      s1_v_q <= rd_v_i && !left_start;
      if (rd_v_i) begin
        s1_col_q   <= col_i - COL_W'(1);
        s1_ch_q    <= ch_i;
        s1_unit_q  <= unit_i;
        s1_first_q <= first_ch_i;
        s1_last_q  <= last_ch_i;
      end
    end
  end

  assign win_o      = win_q;
  assign s1_v_o     = s1_v_q;
  assign s1_col_o   = s1_col_q;
  assign s1_ch_o    = s1_ch_q;
  assign s1_unit_o  = s1_unit_q;
  assign s1_first_o = s1_first_q;
  assign s1_last_o  = s1_last_q;

  assert_pad_left_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && s1_col_q == '0) |-> (win_q[0] == '0 && win_q[3] == '0 && win_q[6] == '0));

  assert_pad_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && s1_col_q == width_i - COL_W'(1)) |->
      (win_q[2] == '0 && win_q[5] == '0 && win_q[8] == '0));

  assert_pad_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && top_i) |-> (win_q[0] == '0 && win_q[1] == '0 && win_q[2] == '0));

  assert_pad_bot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && bot_i) |-> (win_q[6] == '0 && win_q[7] == '0 && win_q[8] == '0));
endmodule

// File: rtl/conv_pe.sv
module conv_pe
  import conv_row_pkg::*;
(
  input  win_t                      win_i,
  input  logic [KTAPS*DATA_W-1:0]   kern_i,
  output logic signed [ACC_W-1:0]   dot_o
);
  logic signed [ACC_W-1:0] prod [KTAPS];
  logic signed [ACC_W-1:0] lvl1 [5];
  logic signed [ACC_W-1:0] lvl2 [3];
  logic signed [ACC_W-1:0] lvl3 [2];

  always_comb begin
    for (int t = 0; t < KTAPS; t++) begin
      prod[t] = ACC_W'(win_i[t]) * ACC_W'(pix_t'(kern_i[t*DATA_W +: DATA_W]));
    end
  end

  // adder tree over the nine products
  always_comb begin
    for (int i = 0; i < 4; i++) lvl1[i] = prod[2*i] + prod[2*i+1];
    lvl1[4] = prod[8];
    lvl2[0] = lvl1[0] + lvl1[1];
    lvl2[1] = lvl1[2] + lvl1[3];
    lvl2[2] = lvl1[4];
    lvl3[0] = lvl2[0] + lvl2[1];
    lvl3[1] = lvl2[2];
    dot_o   = lvl3[0] + lvl3[1];
  end
endmodule

// File: rtl/conv_row_acc.sv
module conv_row_acc
  import conv_row_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int COL_W  = 5,
  parameter int UNIT_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic [COL_W-1:0]        col_i,
  input  logic [UNIT_W-1:0]       unit_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic [NUM_PE*ACC_W-1:0] dot_i,
  output logic                    out_valid_o,
  output logic [UNIT_W-1:0]       out_unit_o,
  output logic [COL_W-1:0]        out_col_o,
  output logic [NUM_PE*ACC_W-1:0] out_data_o
);
  localparam int DEPTH = 1 << COL_W;

  logic signed [ACC_W-1:0] acc_q [DEPTH][NUM_PE];
  logic signed [ACC_W-1:0] dot   [NUM_PE];
  logic signed [ACC_W-1:0] prev  [NUM_PE];
  logic signed [ACC_W-1:0] sum   [NUM_PE];
  logic [NUM_PE*ACC_W-1:0] sum_flat;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_lane
    assign dot[p]  = dot_i[p*ACC_W +: ACC_W];
    assign prev[p] = acc_q[col_i][p];
    // first input channel starts the sum, later channels add into it
    assign sum[p]  = first_i ? dot[p] : prev[p] + dot[p];
    assign sum_flat[p*ACC_W +: ACC_W] = sum[p];

    assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_i && !first_i && (prev[p][ACC_W-1] == dot[p][ACC_W-1])) |->
        (sum[p][ACC_W-1] == dot[p][ACC_W-1]));
  end

  always_ff @(posedge clk_i) begin
    if (v_i) begin
      for (int p = 0; p < NUM_PE; p++) acc_q[col_i][p] <= sum[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_unit_o  <= '0;
      out_col_o   <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= v_i && last_i;
      if (v_i && last_i) begin
        out_unit_o <= unit_i;
        out_col_o  <= col_i;
        out_data_o <= sum_flat;
      end
    end
  end

  assert_out_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o) && out_unit_o == $past(out_unit_o)) |->
      (out_col_o == $past(out_col_o) + COL_W'(1)));
endmodule

// File: rtl/conv_row_engine.sv
module conv_row_engine
  import conv_row_pkg::*;
#(
  parameter int NUM_PE    = 4,
  parameter int MAX_W     = 16,
  parameter int MAX_CIN   = 8,
  parameter int MAX_UNITS = 4,
  localparam int COL_W    = $clog2(MAX_W + 1),
  localparam int CH_W     = $clog2(MAX_CIN + 1),
  localparam int UNIT_W   = $clog2(MAX_UNITS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [COL_W-1:0]              cfg_width_i,
  input  logic [CH_W-1:0]               cfg_cin_i,
  input  logic [UNIT_W-1:0]             cfg_units_i,
  input  logic                          top_edge_i,
  input  logic                          bot_edge_i,
  output logic                          busy_o,
  output logic [CH_W-1:0]               rd_ch_o,
  output logic [COL_W-1:0]              rd_col_o,
  input  logic [DATA_W-1:0]             rd_top_i,
  input  logic [DATA_W-1:0]             rd_mid_i,
  input  logic [DATA_W-1:0]             rd_bot_i,
  output logic [CH_W-1:0]               k_ch_o,
  output logic [UNIT_W-1:0]             k_unit_o,
  input  logic [NUM_PE*KTAPS*DATA_W-1:0] kernel_i,
  output logic                          out_valid_o,
  output logic [UNIT_W-1:0]             out_unit_o,
  output logic [COL_W-1:0]              out_col_o,
  output logic [NUM_PE*ACC_W-1:0]       out_data_o
);
  logic              run, top_q, bot_q, first_ch, last_ch;
  logic [COL_W-1:0]  col, width_q;
  logic [CH_W-1:0]   ch;
  logic [UNIT_W-1:0] unit;
  win_t              win;
  logic              s1_v, s1_first, s1_last;
  logic [COL_W-1:0]  s1_col;
  logic [CH_W-1:0]   s1_ch;
  logic [UNIT_W-1:0] s1_unit;
  logic [NUM_PE*ACC_W-1:0] dots;

  assign busy_o = run || s1_v;

  conv_row_seq #(
    .MAX_W(MAX_W), .MAX_CIN(MAX_CIN), .MAX_UNITS(MAX_UNITS),
    .COL_W(COL_W), .CH_W(CH_W), .UNIT_W(UNIT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy_o),
    .cfg_width_i(cfg_width_i), .cfg_cin_i(cfg_cin_i), .cfg_units_i(cfg_units_i),
    .top_edge_i(top_edge_i), .bot_edge_i(bot_edge_i),
    .run_o(run), .col_o(col), .ch_o(ch), .unit_o(unit), .width_o(width_q),
    .top_o(top_q), .bot_o(bot_q), .first_ch_o(first_ch), .last_ch_o(last_ch)
  );

  assign rd_ch_o  = ch;
  assign rd_col_o = col;

  conv_row_window #(.COL_W(COL_W), .CH_W(CH_W), .UNIT_W(UNIT_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_v_i(run), .col_i(col), .ch_i(ch),
    .unit_i(unit), .first_ch_i(first_ch), .last_ch_i(last_ch),
    .width_i(width_q), .top_i(top_q), .bot_i(bot_q),
    .rd_top_i(rd_top_i), .rd_mid_i(rd_mid_i), .rd_bot_i(rd_bot_i),
    .win_o(win), .s1_v_o(s1_v), .s1_col_o(s1_col), .s1_ch_o(s1_ch),
    .s1_unit_o(s1_unit), .s1_first_o(s1_first), .s1_last_o(s1_last)
  );

  // kernel store is addressed by the window stage
  assign k_ch_o   = s1_ch;
  assign k_unit_o = s1_unit;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    conv_pe u_pe (
      .win_i(win),
      .kern_i(kernel_i[p*KTAPS*DATA_W +: KTAPS*DATA_W]),
      .dot_o(dots[p*ACC_W +: ACC_W])
    );
  end

  conv_row_acc #(.NUM_PE(NUM_PE), .COL_W(COL_W), .UNIT_W(UNIT_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .v_i(s1_v), .col_i(s1_col),
    .unit_i(s1_unit), .first_i(s1_first), .last_i(s1_last), .dot_i(dots),
    .out_valid_o(out_valid_o), .out_unit_o(out_unit_o),
    .out_col_o(out_col_o), .out_data_o(out_data_o)
  );
endmodule

// File: tb/conv_row_engine_test.sv
module conv_row_engine_test;
  localparam int NUM_PE    = 4;
  localparam int MAX_W     = 16;
  localparam int MAX_CIN   = 8;
  localparam int MAX_UNITS = 4;
  localparam int COL_W     = $clog2(MAX_W + 1);
  localparam int CH_W      = $clog2(MAX_CIN + 1);
  localparam int UNIT_W    = $clog2(MAX_UNITS + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [COL_W-1:0]  cfg_width_i = '0;
  logic [CH_W-1:0]   cfg_cin_i = '0;
  logic [UNIT_W-1:0] cfg_units_i = '0;
  logic top_edge_i = 1'b0, bot_edge_i = 1'b0;
  logic busy_o;
  logic [CH_W-1:0]   rd_ch_o;
  logic [COL_W-1:0]  rd_col_o;
  logic [7:0] rd_top_i, rd_mid_i, rd_bot_i;
  logic [CH_W-1:0]   k_ch_o;
  logic [UNIT_W-1:0] k_unit_o;
  logic [NUM_PE*72-1:0] kernel_i;
  logic out_valid_o;
  logic [UNIT_W-1:0] out_unit_o;
  logic [COL_W-1:0]  out_col_o;
  logic [NUM_PE*32-1:0] out_data_o;

  int checks = 0;
  int errors = 0;
  int cur_w = 1, cur_cin = 1, cur_units = 1, cur_mode = 0;
  bit cur_top = 0, cur_bot = 0;

  always #10 clk_i = ~clk_i;

  conv_row_engine #(.NUM_PE(NUM_PE), .MAX_W(MAX_W), .MAX_CIN(MAX_CIN),
                    .MAX_UNITS(MAX_UNITS)) uut (.*);

  function automatic int pv(int mode, int r, int c, int x);
    logic signed [7:0] b;
    if (mode == 1) return -128;
    b = 8'(r*37 + c*11 + x*5 + mode*19 + 7);
    return int'(b);
  endfunction

  function automatic int wv(int mode, int u, int c, int p, int t);
    logic signed [7:0] b;
    if (mode == 1) return -128;
    b = 8'(u*53 + c*29 + p*17 + t*7 + mode*13 + 3);
    return int'(b);
  endfunction

  // row buffer: real data even on edge rows, junk beyond the width
  always_comb begin
    if (int'(rd_col_o) < cur_w) begin
      rd_top_i = 8'(pv(cur_mode, 0, int'(rd_ch_o), int'(rd_col_o)));
      rd_mid_i = 8'(pv(cur_mode, 1, int'(rd_ch_o), int'(rd_col_o)));
      rd_bot_i = 8'(pv(cur_mode, 2, int'(rd_ch_o), int'(rd_col_o)));
    end else begin
      rd_top_i = 8'h5A;
      rd_mid_i = 8'h6B;
      rd_bot_i = 8'h7C;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PE; p++)
      for (int t = 0; t < 9; t++)
        kernel_i[(p*9+t)*8 +: 8] = 8'(wv(cur_mode, int'(k_unit_o), int'(k_ch_o), p, t));
  end

  function automatic int padded(int r, int c, int x);
    if (x < 0 || x >= cur_w) return 0;
    if (r == 0 && cur_top) return 0;
    if (r == 2 && cur_bot) return 0;
    return pv(cur_mode, r, c, x);
  endfunction

  function automatic int expv(int u, int p, int x);
    longint s = 0;
    for (int c = 0; c < cur_cin; c++)
      for (int r = 0; r < 3; r++)
        for (int k = 0; k < 3; k++)
          s += longint'(wv(cur_mode, u, c, p, r*3+k)) * longint'(padded(r, c, x+k-1));
    return int'(s);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(int w, int cin, int units, bit top, bit bot, int mode, bit disturb);
    int n = 0;
    int cyc = 0;
    bit done = 0;
    string base;
    cur_w = w; cur_cin = cin; cur_units = units;
    cur_top = top; cur_bot = bot; cur_mode = mode;
    base = (top || bot) ? "R4" : "R2";
    @(negedge clk_i);
    cfg_width_i = COL_W'(w);
    cfg_cin_i   = CH_W'(cin);
    cfg_units_i = UNIT_W'(units);
    top_edge_i  = top;
    bot_edge_i  = bot;
    start_i     = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8", "busy after start", longint'(busy_o), 1);
    while (!done) begin
      if (out_valid_o) begin
        int eu = n / w;
        int ex = n % w;
        check(int'(out_unit_o) == eu && int'(out_col_o) == ex, "R5", "output position",
              longint'(out_unit_o) * 100 + longint'(out_col_o), longint'(eu) * 100 + ex);
        for (int p = 0; p < NUM_PE; p++) begin
          int act = int'($signed(out_data_o[p*32 +: 32]));
          int exp = expv(eu, p, ex);
          string tag = (ex == 0 || ex == w-1) ? "R3" : base;
          if (disturb) tag = "R7";
          check(act == exp, tag, "lane sum", act, exp);
        end
        n++;
        if (n == w*units)
          check(busy_o == 1'b0, "R8", "busy at last output", longint'(busy_o), 0);
      end
      if (!busy_o) done = 1;
      if (disturb && cyc == 3) begin
        cfg_width_i = COL_W'(1);
        cfg_cin_i   = CH_W'(1);
        cfg_units_i = UNIT_W'(1);
        top_edge_i  = ~top;
        bot_edge_i  = ~bot;
        start_i     = 1'b1;
      end
      if (disturb && cyc == 4) start_i = 1'b0;
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R8", "run timeout", cyc, 0);
        done = 1;
      end
      if (!done) @(negedge clk_i);
    end
    check(n == w*units, "R5", "output count", n, w*units);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      check(!out_valid_o && !busy_o, disturb ? "R6" : "R5", "idle after run",
            longint'(out_valid_o) + 2*longint'(busy_o), 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && out_valid_o == 1'b0, "R1", "reset idle",
          longint'(busy_o) + 2*longint'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && out_valid_o == 1'b0, "R1", "idle after release",
          longint'(busy_o) + 2*longint'(out_valid_o), 0);

    for (int w = 1; w <= 5; w++)
      for (int cin = 1; cin <= 3; cin++)
        for (int units = 1; units <= 2; units++)
          for (int e = 0; e < 4; e++)
            run_case(w, cin, units, e[0], e[1], 0, 0);

    run_case(MAX_W, MAX_CIN, MAX_UNITS, 0, 0, 1, 0);
    run_case(MAX_W, MAX_CIN, MAX_UNITS, 1, 1, 1, 0);
    run_case(MAX_W, MAX_CIN, MAX_UNITS, 0, 1, 2, 0);
    run_case(6, 2, 3, 0, 0, 3, 1);
    run_case(7, 3, 2, 1, 0, 4, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule